// File: doc/BRIEF.md
# Shift-Register Return Address Stack

This block keeps return addresses for a small processor core. It is a fixed chain of registers and has no pointer. A call or an interrupt entry raises `push_en` with the return address on `push_addr`. A return of either kind raises `pop_en`. The program-counter logic reads `top_addr` during that same cycle.

Each push moves every stored entry one level deeper. When all levels are full, the oldest entry drops out of the bottom. Each pop moves every entry one level up, and the deepest level keeps its own value. If a program returns more often than it called, it gets that deepest value again. The block has no overflow flag and no underflow flag.

Top module: `ret_stack`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all three levels to zero, so `top_addr` reads 0 after reset.
- R2: On a push, the next cycle holds `push_addr` in level 0, old level 0 in level 1, and old level 1 in level 2.
- R3: On a pop, the next cycle holds old level 1 in level 0 and old level 2 in level 1. Level 2 keeps its value.
- R4: `top_addr` always equals level 0, with no register in between. During a pop cycle it therefore shows the address being returned.
- R5: A fourth push with no pop in between discards the oldest address. After pushes A1, A2, A3, A4, four pops return A4, A3, A2, A2.
- R6: If `push_en` and `pop_en` are both high in one cycle, only the push takes effect and the pop is ignored.
- R7: With neither request high, all levels keep their values.
- R8: Pops on a stack that was never pushed after reset return 0 and raise no error.
- R9: Entries are `AW` bits wide (default 9). Bits of `push_addr` are stored and returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_en | input | 1 | Store a return address |
| pop_en | input | 1 | Remove the top return address |
| push_addr | input | AW | Return address to store |
| top_addr | output | AW | Current top-of-stack value |

## Verification
A push and a pop can be requested in the same cycle. The random stimulus raises both together about one cycle in eight, and a directed case does so with the stack full. The bench model applies only the push in those cycles. It then pops the stack out until the deepest level repeats. This shows that the lower levels moved down and were not lost to the ignored pop.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int AW    = 9,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_en,
  input  logic          pop_en,
  input  logic [AW-1:0] push_addr,
  output logic [AW-1:0] top_addr
);
  localparam int LAST = DEPTH - 1;

  logic [AW-1:0] lvl [DEPTH];
  logic          do_pop;

  assign do_pop   = pop_en & ~push_en;
  assign top_addr = lvl[0];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [AW-1:0] from_above, from_below;
    if (i == 0) begin : g_top
      assign from_above = push_addr;
    end else begin : g_mid
      assign from_above = lvl[i-1];
    end
    if (i == LAST) begin : g_bot
      assign from_below = lvl[i];
    end else begin : g_up
      assign from_below = lvl[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)          lvl[i] <= '0;
      else if (push_en) lvl[i] <= from_above;
      else if (do_pop)  lvl[i] <= from_below;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (top_addr == '0));
  assert_push_top_R2: assert property (@(posedge clk) disable iff (rst)
    push_en |=> (top_addr == $past(push_addr)));
  assert_push_shift_R2: assert property (@(posedge clk) disable iff (rst)
    push_en |=> (lvl[1] == $past(top_addr)));
  assert_pop_shift_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_en && !push_en) |=> (top_addr == $past(lvl[1])));
  assert_pop_keep_bottom_R3: assert property (@(posedge clk) disable iff (rst)
    (pop_en && !push_en) |=> $stable(lvl[LAST]));
  assert_both_push_wins_R6: assert property (@(posedge clk) disable iff (rst)
    (pop_en && push_en) |=> (top_addr == $past(push_addr)));
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!pop_en && !push_en) |=> ($stable(top_addr) && $stable(lvl[LAST])));
endmodule

// File: tb/test_ret_stack.sv
module test_ret_stack;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;

  logic clk = 0, rst = 1, push_en = 0, pop_en = 0;
  logic [AW-1:0] push_addr = '0;
  logic [AW-1:0] top_addr;
  logic [AW-1:0] m [3];
  int checks = 0, fails = 0;
  bit done = 0;

  ret_stack #(.AW(AW), .DEPTH(3)) i_ret_stack (
    .clk(clk), .rst(rst), .push_en(push_en), .pop_en(pop_en),
    .push_addr(push_addr), .top_addr(top_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic void model_step(bit ps, bit pp, logic [AW-1:0] d);
    if (ps) begin m[2] = m[1]; m[1] = m[0]; m[0] = d; end
    else if (pp) begin m[0] = m[1]; m[1] = m[2]; end
  endfunction

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit ps, bit pp, logic [AW-1:0] d);
    push_en = ps; pop_en = pp; push_addr = d;
    #1 if (pp && !ps) check("R4 top during pop", top_addr, m[0]);
    @(posedge clk); #1;
    model_step(ps, pp, d);
    push_en = 0; pop_en = 0;
  endtask

  task automatic do_reset();
    rst = 1; @(posedge clk); #1; rst = 0;
    m[0] = '0; m[1] = '0; m[2] = '0;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    check("R1 reset", top_addr, 0);
    cyc(0, 1, 0); check("R8 pop empty", top_addr, 0);
    cyc(0, 1, 0); check("R8 pop empty again", top_addr, 0);

    cyc(1, 0, 9'h1A5); check("R2 push top", top_addr, 9'h1A5);
    cyc(1, 0, 9'h0FF); check("R9 width", top_addr, 9'h0FF);
    cyc(0, 0, 0);     check("R7 idle hold", top_addr, 9'h0FF);

    do_reset();
    cyc(1, 0, 9'd11); cyc(1, 0, 9'd22); cyc(1, 0, 9'd33); cyc(1, 0, 9'd44);
    check("R5 top A4", top_addr, 9'd44);
    cyc(0, 1, 0); check("R5 pop1 A3", top_addr, 9'd33);
    cyc(0, 1, 0); check("R5 pop2 A2", top_addr, 9'd22);
    cyc(0, 1, 0); check("R5 pop3 A2 repeat", top_addr, 9'd22);
    cyc(0, 1, 0); check("R3 bottom kept", top_addr, 9'd22);

    do_reset();
    cyc(1, 0, 9'd1); cyc(1, 0, 9'd2); cyc(1, 0, 9'd3);
    cyc(1, 1, 9'd4); check("R6 push wins", top_addr, 9'd4);
    cyc(0, 1, 0); check("R6 level1 shifted", top_addr, 9'd3);
    cyc(0, 1, 0); check("R6 level2 shifted", top_addr, 9'd2);
    cyc(0, 1, 0); check("R6 bottom repeat", top_addr, 9'd2);

    do_reset();
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom_range(0, 7);
      bit ps = (r < 3) || (r == 7);
      bit pp = (r >= 3 && r < 6) || (r == 7);
      cyc(ps, pp, AW'($urandom));
      check("R2 R3 R6 R7 random", top_addr, m[0]);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule